// File: doc/BRIEF.md
# I2C Address-Match and Direction Tracker

This block follows a two-wire serial bus on behalf of a bus controller that can act as either the bus master or an addressed slave. It synchronizes the clock and data lines, detects start and stop conditions, counts clock pulses within each byte, and watches the first byte after a start. From that first byte it decides whether the controller has been addressed and which way data will flow.

It keeps two status flags. The first, `addr_match`, reports that the address received in the first byte equals the controller's own address. The second, `tx_mode`, reports that the controller is the transmitting side. `tx_mode` gates the data-line output enable `sda_oe`. Each flag has its own set and clear events, and some of them depend on the current role. The controller enters the master role by pulsing `mst_start_req` when it issues a start, and it leaves that role on a stop, an exit pulse, a disable or a lost arbitration.

The block does not shift data bytes, stretch the clock or generate the master clock. Its outputs feed the controller's data path and line drivers.

Top module: `i2c_addr_dir_tracker`

## Requirements
- R1: Start (SDA falls while SCL is high) and stop (SDA rises while SCL is high) are detected after a two-flop synchroniser, and each of them returns `bit_cnt` to 0.
- R2: `bit_cnt` increases by one on every SCL rising edge. It reads 8 after the eighth rise of a byte and 9 after the ninth, and it wraps from 9 to 1 on the next rise.
- R3: In the slave role, `addr_match` is set on the eighth SCL rise of the first byte after a start when the seven bits received before it (most significant first) equal `own_addr`. It stays 0 otherwise, including when the master role is active.
- R4: `addr_match` is cleared by a start, a stop, an `exit_pulse`, `enable` going low, and reset.
- R5: A `mst_start_req` pulse while enabled sets `tx_mode` and enters the master role. A bus start seen in the master role does not clear `tx_mode`.
- R6: In the master role, at the eighth SCL rise of the first byte, `mst_dir` = 0 (write) leaves `tx_mode` at 1 and `mst_dir` = 1 (read) clears it.
- R7: In the slave role, at the eighth SCL rise of the first byte, a sampled SDA of 1 with a matching address sets `tx_mode`. A sampled 0 clears it.
- R8: In the slave role, a detected start clears `tx_mode`.
- R9: In either role, a stop, `exit_pulse`, `wait_rel`, a 0-to-1 change of `arb_lost`, `enable` going low, and reset each clear `tx_mode`.
- R10: `sda_oe` is 0 whenever `tx_mode` is 0. In the master role it follows `tx_mode` at once. In the slave role it rises no earlier than the falling SCL edge that ends the first byte's ninth clock.
- R11: When a set event and a clear event for a flag fall in the same cycle, the clear wins.
- R12: While `enable` is 0, both flags stay 0, `bit_cnt` stays 0, and bus activity sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| enable | input | 1 | Block enable; its falling edge clears both flags |
| own_addr | input | ADDR_W | Own slave address |
| mst_start_req | input | 1 | Pulse: the controller is generating a start as master |
| mst_dir | input | 1 | Direction bit the master drives in the first byte (1 = read) |
| exit_pulse | input | 1 | Pulse: leave the current transfer |
| wait_rel | input | 1 | Pulse: release the wait |
| arb_lost | input | 1 | Arbitration-lost indication; its rising edge clears the transmit flag |
| addr_match | output | 1 | Own address received |
| tx_mode | output | 1 | Transmitting side |
| sda_oe | output | 1 | Data-line output enable |
| bit_cnt | output | CNT_W | SCL rising edges counted in the current byte |

## Verification
The bench sweeps every 7-bit address with both direction values against a fixed own address. A comparator that is off by one bit, or that samples on the wrong clock, shows up as a wrong `addr_match` for exactly those addresses. It checks that `sda_oe` stays low in the slave role until the ninth falling edge; a design that drives from the moment `tx_mode` sets would collide with the master's acknowledge. Each clear source is fired on its own against a set `tx_mode`, and a coincident set and clear is checked so that a design with the wrong priority keeps driving the line. The bench also covers a repeated start in both roles, because a design that clears on any start would break the master's own address phase.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;

    // Bus events decoded from the synchronised lines, one cycle wide
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda_lvl;
    } bus_ev_t;

endpackage

// File: rtl/i2c_trk_sync.sv
module i2c_trk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/i2c_trk_bus_events.sv
module i2c_trk_bus_events
    import i2c_trk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

    logic [NUM_LINES-1:0] raw;
    logic [NUM_LINES-1:0] synced;

    assign raw = {sda_in, scl_in};

    // One synchroniser per bus line; both idle high
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2c_trk_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw[g]),
            .q     (synced[g])
        );
    end

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d;
    prev_t prev_q;

    always_comb begin
        prev_d.scl = synced[LINE_SCL];
        prev_d.sda = synced[LINE_SDA];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    always_comb begin
        ev.scl_rise = synced[LINE_SCL] & ~prev_q.scl;
        ev.scl_fall = ~synced[LINE_SCL] & prev_q.scl;
        ev.start    = synced[LINE_SCL] & prev_q.scl & ~synced[LINE_SDA] & prev_q.sda;
        ev.stop     = synced[LINE_SCL] & prev_q.scl & synced[LINE_SDA] & ~prev_q.sda;
        ev.sda_lvl  = synced[LINE_SDA];
    end

endmodule

// File: rtl/i2c_trk_byte_track.sv
module i2c_trk_byte_track
    import i2c_trk_pkg::*;
#(
    parameter  int ADDR_W = 7,
    localparam int CNT_W  = $clog2(ADDR_W + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  bus_ev_t           ev,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              addr_strobe,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              data_phase
);

    // Clocks per byte: address bits, direction bit, acknowledge
    localparam int BYTE_CLKS = ADDR_W + 2;
    // Count value held just before the direction-bit rise
    localparam int DIR_IDX   = ADDR_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              first;
        logic              data;
        logic [ADDR_W-1:0] sh;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (ev.start || ev.stop) begin
            st_d.cnt   = '0;
            st_d.first = ev.start;
            st_d.data  = 1'b0;
            st_d.sh    = '0;
        end else begin
            if (ev.scl_rise) begin
                if (st_q.cnt == CNT_W'(BYTE_CLKS)) st_d.cnt = CNT_W'(1);
                else                               st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.first && (st_q.cnt < CNT_W'(DIR_IDX))) begin
                    st_d.sh = {st_q.sh[ADDR_W-2:0], ev.sda_lvl};
                end
            end
            // Falling edge that closes the first byte's acknowledge clock
            if (ev.scl_fall && st_q.first && (st_q.cnt == CNT_W'(BYTE_CLKS))) begin
                st_d.first = 1'b0;
                st_d.data  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_cnt     = st_q.cnt;
    assign rx_addr     = st_q.sh;
    assign data_phase  = st_q.data;
    assign addr_strobe = enable & ev.scl_rise & st_q.first & (st_q.cnt == CNT_W'(DIR_IDX));

    // R2: count never passes the byte length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(BYTE_CLKS));

    // R2: wrap after the acknowledge clock
    p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ev.scl_rise && st_q.cnt == CNT_W'(BYTE_CLKS)) |=> (st_q.cnt == CNT_W'(1)));

    // R1: start and stop restart the count
    p_cond_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (ev.start || ev.stop)) |=> (st_q.cnt == '0));

    // R12: disabled block holds an idle count
    p_disabled_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.cnt == '0 && !st_q.data));

endmodule

// File: rtl/i2c_trk_flags.sv
module i2c_trk_flags #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              mst_start_req,
    input  logic              mst_dir,
    input  logic              exit_pulse,
    input  logic              wait_rel,
    input  logic              arb_lost,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_strobe,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              rx_dir,
    output logic              addr_match,
    output logic              tx_mode,
    output logic              master
);

    typedef struct packed {
        logic match;
        logic tx;
        logic mst;
        logic en_prev;
        logic arb_prev;
    } fl_t;

    fl_t fl_d;
    fl_t fl_q;

    logic en_fall;
    logic arb_rise;
    logic addr_eq;
    logic match_clr, match_set;
    logic mst_clr, mst_set;
    logic tx_clr, tx_set;

    always_comb begin
        en_fall   = fl_q.en_prev & ~enable;
        arb_rise  = arb_lost & ~fl_q.arb_prev;
        addr_eq   = (rx_addr == own_addr);

        match_clr = start_det | stop_det | exit_pulse | en_fall | ~enable;
        match_set = addr_strobe & ~fl_q.mst & addr_eq;

        mst_clr   = stop_det | exit_pulse | en_fall | arb_rise | ~enable;
        mst_set   = mst_start_req;

        tx_clr    = stop_det | exit_pulse | en_fall | wait_rel | arb_rise | ~enable
                  | (start_det & ~fl_q.mst)
                  | (addr_strobe & fl_q.mst & mst_dir)
                  | (addr_strobe & ~fl_q.mst & ~rx_dir);
        tx_set    = mst_start_req
                  | (addr_strobe & fl_q.mst & ~mst_dir)
                  | (addr_strobe & ~fl_q.mst & addr_eq & rx_dir);

        fl_d          = fl_q;
        fl_d.en_prev  = enable;
        fl_d.arb_prev = arb_lost;

        // Clear events take priority over set events
        if (match_clr)      fl_d.match = 1'b0;
        else if (match_set) fl_d.match = 1'b1;

        if (mst_clr)        fl_d.mst = 1'b0;
        else if (mst_set)   fl_d.mst = 1'b1;

        if (tx_clr)         fl_d.tx = 1'b0;
        else if (tx_set)    fl_d.tx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign addr_match = fl_q.match;
    assign tx_mode    = fl_q.tx;
    assign master     = fl_q.mst;

    // R9: exit leaves both flags clear
    p_exit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |=> (!fl_q.tx && !fl_q.match));

    // R9: wait release drops the transmit flag
    p_wait_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_rel |=> !fl_q.tx);

    // R4: any start drops the match flag
    p_start_unmatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !fl_q.match);

    // R8: slave-side start drops the transmit flag
    p_slave_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !fl_q.mst) |=> !fl_q.tx);

    // R11: coincident start request and exit end clear
    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_start_req && exit_pulse) |=> (!fl_q.tx && !fl_q.mst));

    // R6: master read direction drops the transmit flag
    p_master_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && fl_q.mst && mst_dir) |=> !fl_q.tx);

    // R3: the match flag never rises while the master role is held
    p_no_master_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.mst && !fl_q.match) |=> !fl_q.match);

endmodule

// File: rtl/i2c_addr_dir_tracker.sv
module i2c_addr_dir_tracker
    import i2c_trk_pkg::*;
#(
    parameter  int ADDR_W      = 7,
    parameter  int SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(ADDR_W + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              enable,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              mst_start_req,
    input  logic              mst_dir,
    input  logic              exit_pulse,
    input  logic              wait_rel,
    input  logic              arb_lost,
    output logic              addr_match,
    output logic              tx_mode,
    output logic              sda_oe,
    output logic [CNT_W-1:0]  bit_cnt
);

    bus_ev_t           ev;
    logic              addr_strobe;
    logic [ADDR_W-1:0] rx_addr;
    logic              data_phase;
    logic              master;

    i2c_trk_bus_events #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_trk_byte_track #(
        .ADDR_W (ADDR_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .ev          (ev),
        .bit_cnt     (bit_cnt),
        .addr_strobe (addr_strobe),
        .rx_addr     (rx_addr),
        .data_phase  (data_phase)
    );

    i2c_trk_flags #(
        .ADDR_W (ADDR_W)
    ) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .own_addr      (own_addr),
        .mst_start_req (mst_start_req),
        .mst_dir       (mst_dir),
        .exit_pulse    (exit_pulse),
        .wait_rel      (wait_rel),
        .arb_lost      (arb_lost),
        .start_det     (ev.start),
        .stop_det      (ev.stop),
        .addr_strobe   (addr_strobe),
        .rx_addr       (rx_addr),
        .rx_dir        (ev.sda_lvl),
        .addr_match    (addr_match),
        .tx_mode       (tx_mode),
        .master        (master)
    );

    // Slave drive waits for the end of the first byte; master drives at once
    assign sda_oe = tx_mode & (master | data_phase);

    // R10: a slave never drives during the address byte
    p_slave_late_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && !data_phase) |-> !sda_oe);

endmodule

// File: tb/sim_i2c_addr_dir_tracker.sv
module sim_i2c_addr_dir_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 7;
    localparam int CNT_W      = $clog2(ADDR_W + 3);
    localparam int SETTLE     = 4;
    localparam logic [ADDR_W-1:0] OWN = 7'h5A;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_in = 1'b1;
    logic              sda_in = 1'b1;
    logic              enable = 1'b1;
    logic [ADDR_W-1:0] own_addr = OWN;
    logic              mst_start_req = 1'b0;
    logic              mst_dir = 1'b0;
    logic              exit_pulse = 1'b0;
    logic              wait_rel = 1'b0;
    logic              arb_lost = 1'b0;
    logic              addr_match;
    logic              tx_mode;
    logic              sda_oe;
    logic [CNT_W-1:0]  bit_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_dir_tracker #(.ADDR_W(ADDR_W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .enable        (enable),
        .own_addr      (own_addr),
        .mst_start_req (mst_start_req),
        .mst_dir       (mst_dir),
        .exit_pulse    (exit_pulse),
        .wait_rel      (wait_rel),
        .arb_lost      (arb_lost),
        .addr_match    (addr_match),
        .tx_mode       (tx_mode),
        .sda_oe        (sda_oe),
        .bit_cnt       (bit_cnt)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_scl(input logic v);
        scl_in = v;
        step(SETTLE);
    endtask

    task automatic set_sda(input logic v);
        sda_in = v;
        step(SETTLE);
    endtask

    task automatic send_bit(input logic b);
        set_sda(b);
        set_scl(1'b1);
        set_scl(1'b0);
    endtask

    task automatic bus_start();
        set_scl(1'b0);
        set_sda(1'b1);
        set_scl(1'b1);
        set_sda(1'b0);
        set_scl(1'b0);
    endtask

    task automatic bus_stop();
        set_scl(1'b0);
        set_sda(1'b0);
        set_scl(1'b1);
        set_sda(1'b1);
    endtask

    // Start, seven address bits and the direction bit; the bus is left with SCL high
    task automatic first_byte_to_dir(input logic [ADDR_W-1:0] a, input logic d);
        bus_start();
        for (int i = ADDR_W - 1; i >= 0; i--) send_bit(a[i]);
        set_sda(d);
        set_scl(1'b1);
    endtask

    // Full slave-side first byte with checks; the bus is left after the ninth fall
    task automatic slave_first_byte(input logic [ADDR_W-1:0] a, input logic d, input bit en);
        bit m;
        bit t;
        m = en && (a == OWN);
        t = m && d;
        first_byte_to_dir(a, d);
        check("R2 count at 8th rise", int'(bit_cnt), en ? 8 : 0);
        check("R3 match at 8th rise", int'(addr_match), int'(m));
        check("R7 slave direction", int'(tx_mode), int'(t));
        check("R10 no slave drive in first byte", int'(sda_oe), 0);
        set_scl(1'b0);
        set_sda(1'b1);
        set_scl(1'b1);
        check("R2 count at 9th rise", int'(bit_cnt), en ? 9 : 0);
        set_scl(1'b0);
        check("R10 slave drive after 9th fall", int'(sda_oe), int'(t));
    endtask

    task automatic check_idle(input string req);
        check(req, int'(addr_match), 0);
        check(req, int'(tx_mode), 0);
        check(req, int'(sda_oe), 0);
    endtask

    task automatic pulse_start_req();
        mst_start_req = 1'b1;
        step(1);
        mst_start_req = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        check_idle("R9 reset state");
        check("R1 reset count", int'(bit_cnt), 0);

        // Sweep every address with both directions
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            for (int d = 0; d < 2; d++) begin
                slave_first_byte(ADDR_W'(a), d[0], 1'b1);
                bus_stop();
                check_idle("R4 R9 stop clears");
                check("R1 stop count", int'(bit_cnt), 0);
            end
        end

        // Wrap of the count and repeated start in the slave role
        slave_first_byte(OWN, 1'b1, 1'b1);
        send_bit(1'b1);
        check("R2 wrap to 1", int'(bit_cnt), 1);
        check("R7 read keeps transmit", int'(tx_mode), 1);
        set_sda(1'b1);
        set_scl(1'b1);
        set_sda(1'b0);
        check("R8 slave start clears transmit", int'(tx_mode), 0);
        check("R4 start clears match", int'(addr_match), 0);
        check("R1 start count", int'(bit_cnt), 0);
        bus_stop();

        // Individual clear sources against a set transmit flag
        slave_first_byte(OWN, 1'b1, 1'b1);
        exit_pulse = 1'b1; step(1); exit_pulse = 1'b0;
        check_idle("R4 R9 exit clears");
        bus_stop();

        slave_first_byte(OWN, 1'b1, 1'b1);
        wait_rel = 1'b1; step(1); wait_rel = 1'b0;
        check("R9 wait release clears", int'(tx_mode), 0);
        check("R10 wait release drops drive", int'(sda_oe), 0);
        check("R9 wait release keeps match", int'(addr_match), 1);
        bus_stop();

        slave_first_byte(OWN, 1'b1, 1'b1);
        arb_lost = 1'b1; step(1);
        check("R9 arbitration loss clears", int'(tx_mode), 0);
        arb_lost = 1'b0;
        bus_stop();

        slave_first_byte(OWN, 1'b1, 1'b1);
        enable = 1'b0; step(1);
        check_idle("R4 R9 disable clears");
        check("R12 disable count", int'(bit_cnt), 0);
        bus_stop();
        slave_first_byte(OWN, 1'b1, 1'b0);
        check_idle("R12 disabled ignores bus");
        bus_stop();
        enable = 1'b1;
        step(2);

        // Master role, both directions, with own address on the bus
        for (int d = 0; d < 2; d++) begin
            mst_dir = d[0];
            pulse_start_req();
            check("R5 start request sets transmit", int'(tx_mode), 1);
            check("R10 master drives at once", int'(sda_oe), 1);
            first_byte_to_dir(OWN, d[0]);
            check("R5 bus start keeps master transmit", int'(tx_mode), d == 0 ? 1 : 0);
            check("R6 master direction", int'(tx_mode), d == 0 ? 1 : 0);
            check("R3 no match as master", int'(addr_match), 0);
            check("R10 master drive follows flag", int'(sda_oe), d == 0 ? 1 : 0);
            bus_stop();
            check_idle("R9 master stop clears");
        end

        // Coincident set and clear
        mst_start_req = 1'b1;
        exit_pulse    = 1'b1;
        step(1);
        mst_start_req = 1'b0;
        exit_pulse    = 1'b0;
        check("R11 clear beats set", int'(tx_mode), 0);
        check("R11 no drive", int'(sda_oe), 0);

        // Arbitration loss drops the master role: a later bus start clears transmit
        pulse_start_req();
        arb_lost = 1'b1; step(1); arb_lost = 1'b0;
        check("R9 master arbitration loss", int'(tx_mode), 0);
        slave_first_byte(OWN, 1'b1, 1'b1);
        bus_stop();

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule